// File: doc/BRIEF.md
# Front-End Slave Identification Register Bank

This block holds the identity and power-mode registers of a serial radio front-end slave. It receives write requests that an upstream frame decoder has already taken apart. Each request carries the slave-ID field of the command, a register address and a data byte. The block decides whether the request may change any state. Reads are served combinationally from a separate read address, so the frame layer can return the byte in the same cycle it asks for it.

The block has four registers:

- A power-mode register.
- A product identifier. Its lowest bit comes from a factory fuse input.
- A fixed manufacturer code.
- The slave identifier register. It keeps a constant upper nibble above the writable 4-bit identifier.

A new identifier is accepted in two cases:

- The command is a broadcast, with a slave-ID field of zero.
- The command addresses the slave by its current identifier.

In both cases the upper nibble of the data must equal the fixed pattern. Power-mode writes always need a matching identifier. Choosing the startup mode returns the identifier to its default.

An asynchronous active-low reset restores every register. A separate software-reset strobe returns only the power mode to active and leaves the identifier alone.

Top module: `fe_slave_id_regs`

## Requirements
- R1: While `rst_n` is low, and after it is released, the identifier is 4'b0111 and the power mode is 2'b00 (active). A read of address 0x1F then returns 0x17.
- R2: A read of address 0x1D returns 7'b0010000 in bits [7:1] and the current value of `fuse_bit` in bit 0.
- R3: A read of address 0x1E always returns 0x2E. A write to 0x1D or 0x1E changes no register.
- R4: A write to address 0x1F may load data bits [3:0] into the identifier only when `wr_sid` is 4'b0000 or equals the current identifier. A write with any other `wr_sid` leaves the identifier unchanged.
- R5: A write to address 0x1F loads the identifier only when data bits [7:4] equal 4'b0001. Any other pattern leaves the identifier unchanged.
- R6: A write to address 0x1C with `wr_sid` equal to the current identifier stores data bits [7:6] as the power mode. The codes are 00 active, 01 startup, 10 low power and 11 reserved. Code 11 and non-matching writes leave the mode unchanged. A read of 0x1C returns the mode in bits [7:6] and zeros below.
- R7: An accepted write of code 01 to address 0x1C returns the identifier to 4'b0111 on the same clock edge.
- R8: A high `soft_rst` at a clock edge sets the power mode to active and never changes the identifier. It takes priority over a power-mode write in the same cycle.
- R9: A read of any address other than 0x1C to 0x1F returns 0x00. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low digital reset |
| soft_rst | input | 1 | Software reset strobe for the power mode only |
| fuse_bit | input | 1 | Static factory-programmed product-ID bit |
| wr_en | input | 1 | Write request valid for one cycle |
| wr_sid | input | 4 | Slave-ID field of the write command |
| wr_addr | input | 5 | Target register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Combinational read data |
| sid_out | output | 4 | Current slave identifier |
| mode_out | output | 2 | Current power-mode code |

## Verification
The assertions assume two things about the inputs. First, each write request is a one-cycle pulse whose address, slave-ID field and data are stable across the sampling edge. Second, `rd_addr` is settled at the edge when the read properties are evaluated. The stimulus meets both assumptions. It changes inputs only on falling edges, drops `wr_en` and `soft_rst` right after the edge that consumes them, and sweeps read addresses only while no write is pending. A single case deliberately raises the software reset together with a power-mode write, to exercise the priority between the two.

// File: rtl/fe_id_pkg.sv
package fe_id_pkg;

   typedef enum logic [1:0] {
      PM_ACTIVE  = 2'b00,
      PM_STARTUP = 2'b01,
      PM_LOWPWR  = 2'b10,
      PM_RSVD    = 2'b11
   } pwr_mode_e;

   localparam int MODE_W = 2;

endpackage

// File: rtl/fe_id_wr_decode.sv
module fe_id_wr_decode
   import fe_id_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 8,
   parameter int SID_W       = 4,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 5'h1C,
   parameter logic [ADDR_W-1:0] SID_ADDR  = 5'h1F,
   parameter logic [DATA_W-SID_W-1:0] SID_UPPER = 4'b0001,
   parameter bit CHECK_UPPER = 1'b1
) (
   input  logic              wr_en,
   input  logic [SID_W-1:0]  wr_sid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SID_W-1:0]  cur_sid,
   output logic              sid_load,
   output logic              mode_load,
   output logic              startup_hit,
   output pwr_mode_e         new_mode
);

   localparam logic [SID_W-1:0] BCAST_SID = '0;

   logic sid_match;
   logic sid_bcast;
   logic upper_ok;
   logic mode_hit;

   assign sid_match = (wr_sid == cur_sid);
   assign sid_bcast = (wr_sid == BCAST_SID);

   if (CHECK_UPPER) begin : g_upper_chk
      assign upper_ok = (wr_data[DATA_W-1:SID_W] == SID_UPPER);
   end else begin : g_upper_free
      assign upper_ok = 1'b1;
   end

   assign new_mode = pwr_mode_e'(wr_data[DATA_W-1 -: MODE_W]);

   always_comb begin
      sid_load    = wr_en && (wr_addr == SID_ADDR) && (sid_bcast || sid_match) && upper_ok;
      mode_hit    = wr_en && (wr_addr == MODE_ADDR) && sid_match;
      mode_load   = mode_hit && (new_mode != PM_RSVD);
      startup_hit = mode_hit && (new_mode == PM_STARTUP);
   end

endmodule

// File: rtl/fe_id_sid_reg.sv
module fe_id_sid_reg #(
   parameter int SID_W = 4,
   parameter logic [SID_W-1:0] SID_RESET = 4'b0111
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sid_load,
   input  logic [SID_W-1:0] sid_data,
   input  logic             startup_hit,
   output logic [SID_W-1:0] sid_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sid_q <= SID_RESET;
      end else if (startup_hit) begin
         sid_q <= SID_RESET;
      end else if (sid_load) begin
         sid_q <= sid_data;
      end
   end

   AST_SID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sid_load && !startup_hit) |=> $stable(sid_q)); // R4

   AST_SID_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
      startup_hit |=> (sid_q == SID_RESET)); // R7

endmodule

// File: rtl/fe_id_mode_reg.sv
module fe_id_mode_reg
   import fe_id_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      soft_rst,
   input  logic      mode_load,
   input  pwr_mode_e new_mode,
   output pwr_mode_e mode_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PM_ACTIVE;
      end else if (soft_rst) begin
         mode_q <= PM_ACTIVE;
      end else if (mode_load) begin
         mode_q <= new_mode;
      end
   end

   AST_MODE_NEVER_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != PM_RSVD); // R6

   AST_MODE_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (mode_q == PM_ACTIVE)); // R8

endmodule

// File: rtl/fe_id_read_mux.sv
module fe_id_read_mux
   import fe_id_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   parameter int SID_W  = 4,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 5'h1C,
   parameter logic [ADDR_W-1:0] PROD_ADDR = 5'h1D,
   parameter logic [ADDR_W-1:0] MFR_ADDR  = 5'h1E,
   parameter logic [ADDR_W-1:0] SID_ADDR  = 5'h1F,
   parameter logic [DATA_W-2:0] PROD_HI   = 7'b0010000,
   parameter logic [DATA_W-1:0] MFR_CODE  = 8'h2E,
   parameter logic [DATA_W-SID_W-1:0] SID_UPPER = 4'b0001,
   parameter bit FUSE_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              fuse_bit,
   input  logic [SID_W-1:0]  sid_q,
   input  pwr_mode_e         mode_q,
   output logic [DATA_W-1:0] rd_data
);

   localparam int MODE_PAD = DATA_W - MODE_W;

   logic prod_lsb;

   if (FUSE_PRESENT) begin : g_fuse
      assign prod_lsb = fuse_bit;
   end else begin : g_no_fuse
      assign prod_lsb = 1'b0;
   end

   always_comb begin
      unique case (rd_addr)
         MODE_ADDR: rd_data = {mode_q, {MODE_PAD{1'b0}}};
         PROD_ADDR: rd_data = {PROD_HI, prod_lsb};
         MFR_ADDR:  rd_data = MFR_CODE;
         SID_ADDR:  rd_data = {SID_UPPER, sid_q};
         default:   rd_data = '0;
      endcase
   end

   AST_MFR_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == MFR_ADDR) |-> (rd_data == MFR_CODE)); // R3

   AST_PROD_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == PROD_ADDR) |-> (rd_data[DATA_W-1:1] == PROD_HI)); // R2

endmodule

// File: rtl/fe_slave_id_regs.sv
module fe_slave_id_regs
   import fe_id_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   parameter int SID_W  = 4,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 5'h1C,
   parameter logic [ADDR_W-1:0] PROD_ADDR = 5'h1D,
   parameter logic [ADDR_W-1:0] MFR_ADDR  = 5'h1E,
   parameter logic [ADDR_W-1:0] SID_ADDR  = 5'h1F,
   parameter logic [DATA_W-2:0] PROD_HI   = 7'b0010000,
   parameter logic [DATA_W-1:0] MFR_CODE  = 8'h2E,
   parameter logic [DATA_W-SID_W-1:0] SID_UPPER = 4'b0001,
   parameter logic [SID_W-1:0] SID_RESET = 4'b0111,
   parameter bit CHECK_UPPER  = 1'b1,
   parameter bit FUSE_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              fuse_bit,
   input  logic              wr_en,
   input  logic [SID_W-1:0]  wr_sid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [SID_W-1:0]  sid_out,
   output logic [1:0]        mode_out
);

   // elaboration-time parameter checks
   if (SID_W + MODE_W > DATA_W) begin : g_bad_width
      $error("identifier and mode fields do not fit in the data byte");
   end
   if ((MODE_ADDR == PROD_ADDR) || (MODE_ADDR == MFR_ADDR) || (MODE_ADDR == SID_ADDR) ||
       (PROD_ADDR == MFR_ADDR) || (PROD_ADDR == SID_ADDR) || (MFR_ADDR == SID_ADDR)) begin : g_bad_addr
      $error("register addresses must be distinct");
   end
   if (SID_RESET == '0) begin : g_bad_reset
      $error("identifier default must differ from the broadcast value");
   end

   logic      sid_load;
   logic      mode_load;
   logic      startup_hit;
   pwr_mode_e new_mode;
   pwr_mode_e mode_q;
   logic [SID_W-1:0] sid_q;

   fe_id_wr_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SID_W(SID_W),
      .MODE_ADDR(MODE_ADDR), .SID_ADDR(SID_ADDR),
      .SID_UPPER(SID_UPPER), .CHECK_UPPER(CHECK_UPPER)
   ) u_dec (
      .wr_en(wr_en), .wr_sid(wr_sid), .wr_addr(wr_addr), .wr_data(wr_data),
      .cur_sid(sid_q), .sid_load(sid_load), .mode_load(mode_load),
      .startup_hit(startup_hit), .new_mode(new_mode)
   );

   fe_id_sid_reg #(
      .SID_W(SID_W), .SID_RESET(SID_RESET)
   ) u_sid (
      .clk(clk), .rst_n(rst_n), .sid_load(sid_load),
      .sid_data(wr_data[SID_W-1:0]), .startup_hit(startup_hit), .sid_q(sid_q)
   );

   fe_id_mode_reg u_mode (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .mode_load(mode_load), .new_mode(new_mode), .mode_q(mode_q)
   );

   fe_id_read_mux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SID_W(SID_W),
      .MODE_ADDR(MODE_ADDR), .PROD_ADDR(PROD_ADDR), .MFR_ADDR(MFR_ADDR),
      .SID_ADDR(SID_ADDR), .PROD_HI(PROD_HI), .MFR_CODE(MFR_CODE),
      .SID_UPPER(SID_UPPER), .FUSE_PRESENT(FUSE_PRESENT)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .fuse_bit(fuse_bit),
      .sid_q(sid_q), .mode_q(mode_q), .rd_data(rd_data)
   );

   assign sid_out  = sid_q;
   assign mode_out = mode_q;

   AST_SID_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == SID_ADDR) && (wr_sid != '0) && (wr_sid != sid_out))
      |=> $stable(sid_out)); // R4

   AST_SID_UPPER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (CHECK_UPPER && wr_en && (wr_addr == SID_ADDR) && (wr_data[DATA_W-1:SID_W] != SID_UPPER))
      |=> $stable(sid_out)); // R5

   AST_MODE_RSVD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !soft_rst && (wr_addr == MODE_ADDR) && (wr_data[DATA_W-1 -: MODE_W] == 2'b11))
      |=> $stable(mode_out)); // R6

   AST_STARTUP_SID: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == MODE_ADDR) && (wr_sid == sid_out) && (wr_data[DATA_W-1 -: MODE_W] == 2'b01))
      |=> (sid_out == SID_RESET)); // R7

   AST_SOFT_SID_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !wr_en) |=> $stable(sid_out)); // R8

   AST_ID_ONLY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr != MODE_ADDR) && (wr_addr != SID_ADDR) && !soft_rst)
      |=> ($stable(sid_out) && $stable(mode_out))); // R9

endmodule

// File: tb/fe_slave_id_regs_tb_top.sv
`timescale 1ns/100ps
module fe_slave_id_regs_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       fuse_bit = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_sid = '0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [4:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [3:0] sid_out;
   logic [1:0] mode_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // behavioural reference state
   int m_sid  = 7;
   int m_mode = 0;

   always #2 clk = ~clk;   // 250 MHz

   fe_slave_id_regs dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fuse_bit(fuse_bit),
      .wr_en(wr_en), .wr_sid(wr_sid), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .sid_out(sid_out), .mode_out(mode_out)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_read(input int a);
      case (a)
         'h1C:    return m_mode * 64;
         'h1D:    return 'h20 + int'(fuse_bit);
         'h1E:    return 'h2E;
         'h1F:    return 'h10 + m_sid;
         default: return 0;
      endcase
   endfunction

   task automatic check_all(input string lbl);
      int addrs[6] = '{'h1C, 'h1D, 'h1E, 'h1F, 'h05, 'h00};
      string reqs[6] = '{"R6", "R2", "R3", "R4", "R9", "R9"};
      check("R4", {lbl, " sid_out"}, int'(sid_out), m_sid);
      check("R6", {lbl, " mode_out"}, int'(mode_out), m_mode);
      for (int i = 0; i < 6; i++) begin
         rd_addr = addrs[i][4:0];
         #0.1;
         check(reqs[i], $sformatf("%s read 0x%0h", lbl, addrs[i]), int'(rd_data), exp_read(addrs[i]));
      end
   endtask

   // one request, model update at the consuming edge, then full comparison
   task automatic step(input logic we, input int s, input int a, input int d,
                       input logic sr, input string lbl);
      int ns;
      int nm;
      @(negedge clk);
      wr_en = we; wr_sid = s[3:0]; wr_addr = a[4:0]; wr_data = d[7:0]; soft_rst = sr;
      @(posedge clk);
      ns = m_sid;
      nm = m_mode;
      if (we && a == 'h1F && (s == 0 || s == m_sid) && (d / 16) == 1) ns = d % 16;
      if (we && a == 'h1C && s == m_sid) begin
         if ((d / 64) != 3) nm = d / 64;
         if ((d / 64) == 1) ns = 7;
      end
      if (sr) nm = 0;
      m_sid = ns;
      m_mode = nm;
      #0.5;
      wr_en = 1'b0; soft_rst = 1'b0;
      check_all(lbl);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hang expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state, held and released
      #5;
      check_all("R1 in reset");
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after release");

      // R2: fuse bit reflected in product ID
      fuse_bit = 1'b1;
      #0.1;
      check_all("R2 fuse=1");

      // R3: product/manufacturer writes ignored
      step(1, 7, 'h1D, 'hFF, 0, "R3 wr 0x1D");
      step(1, 7, 'h1E, 'h00, 0, "R3 wr 0x1E");

      // R4: matching, broadcast and foreign identifiers
      step(1, 7, 'h1F, 'h1A, 0, "R4 match load");
      step(1, 0, 'h1F, 'h13, 0, "R4 broadcast load");
      step(1, 5, 'h1F, 'h19, 0, "R4 foreign ignored");
      step(1, 10, 'h1F, 'h1C, 0, "R4 stale id ignored");

      // R5: upper nibble must be the fixed pattern
      step(1, 0, 'h1F, 'h29, 0, "R5 upper 2 ignored");
      step(1, 3, 'h1F, 'h09, 0, "R5 upper 0 ignored");
      step(1, 3, 'h1F, 'hF5, 0, "R5 upper F ignored");

      // R6: power mode writes
      step(1, 3, 'h1C, 'h80, 0, "R6 low power");
      step(1, 3, 'h1C, 'hC0, 0, "R6 reserved kept");
      step(1, 4, 'h1C, 'h00, 0, "R6 foreign ignored");
      step(1, 0, 'h1C, 'h00, 0, "R6 broadcast ignored");
      step(1, 3, 'h1C, 'h3F, 0, "R6 active");

      // R7: startup restores the identifier
      step(1, 3, 'h1C, 'h40, 0, "R7 startup");
      step(1, 0, 'h1F, 'h1C, 0, "R7 reload id");
      step(1, 7, 'h1C, 'h40, 0, "R7 stale id no startup");

      // R8: software reset
      step(1, 12, 'h1C, 'h80, 0, "R8 prep low power");
      step(0, 0, 'h00, 'h00, 1, "R8 soft reset");
      step(1, 12, 'h1C, 'h80, 1, "R8 soft beats write");
      step(1, 0, 'h1F, 'h15, 1, "R8 soft with id write");

      // R9: unmapped writes
      step(1, 5, 'h05, 'hFF, 0, "R9 wr 0x05");
      step(1, 5, 'h00, 'h1A, 0, "R9 wr 0x00");

      // R1: asynchronous reset mid-run
      step(1, 5, 'h1C, 'h80, 0, "R1 prep");
      @(negedge clk);
      rst_n = 1'b0;
      #0.5;
      m_sid = 7;
      m_mode = 0;
      check_all("R1 async reset");
      @(negedge clk) rst_n = 1'b1;
      fuse_bit = 1'b0;
      @(negedge clk);
      check_all("R1 R2 after second reset");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule